// File: doc/BRIEF.md
# Sparse Matrix-Vector Multiply Engine

This block is one sequential processing element that computes y = A·x for an N×N matrix whose nonzero entries alone are stored on chip. Every nonzero sits in a coordinate memory together with its row and column index. The entries are ordered by column. A single one-word input stream carries the matrix load words and the vector elements. A single output stream carries the results.

Work on a vector is split into two passes. In the product pass the unit takes x_j for each column j in turn. It multiplies x_j by every stored nonzero of that column and writes each full-precision product, tagged with its row, into the next location of a product buffer. In the summation pass the unit clears all row accumulators, walks the product buffer once to add each product into its row's accumulator, and then emits y_0 to y_{N-1} in row order. The running time grows with N plus the nonzero count, not with N².

The matrix can stay resident and serve many vectors, or it can be reloaded ahead of each vector. A level input chooses between the two at the start of each job. Both modes run the same compute sequence.

Top module: `spmv_engine`

## Requirements
- R1: After reset, out_valid, done and load_err are low. A resident job started before any load sees an empty matrix.
- R2: When reload is high at the start of a job, the input stream carries a count word and then, for each nonzero, three words: row, column and value. Row and column sit in the low log2(N) bits. The value is a DATA_W-bit two's-complement number. The triples arrive sorted by ascending column. The vector words follow directly.
- R3: A count word greater than DEPTH raises load_err and empties the stored matrix. No triple is taken, and the unit returns to wait for the next job. A count of DEPTH or less clears load_err.
- R4: A job takes N vector words, x_0 first. Output word i is the exact sum over the stored entries of row i of value·x_col. Products are 2·DATA_W bits wide and the accumulators are 2·DATA_W+log2(N) bits wide, so even full-scale negative operands do not overflow.
- R5: When reload is low at the start of a job, the unit goes straight to the vector words and reuses the matrix stored last.
- R6: A column with no stored entry still takes its x_j word and adds nothing. A matrix loaded with count 0 yields all-zero outputs.
- R7: Results leave as y_0 to y_{N-1} over a valid/ready handshake. While out_valid is high and out_ready is low, out_data holds steady.
- R8: done is high for exactly one cycle, the cycle after the handshake of the last result. in_ready is low while results are being emitted and while done is high.
- R9: With the vector words offered back to back, out_valid rises no more than 2·N + 2·M + 4 cycles after the first vector word is accepted, where M is the stored nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reload | input | 1 | Sampled at job start: 1 loads a new matrix first, 0 reuses the stored one |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unit accepts an input word |
| in_data | input | DATA_W | Count, row, column, value or vector word |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer accepts a result word |
| out_data | output | 2·DATA_W+log2(N) | Signed result y_i |
| done | output | 1 | One-cycle pulse after the last result |
| load_err | output | 1 | Last count word exceeded the memory depth |

## Verification
The assertions assume that every row and column word is below N and that the triples of one load arrive sorted by ascending column. A triple that breaks the column order would never be matched in the product pass, so the expected sums would not hold. The bench builds each matrix column by column, and it keeps every index inside 0..N-1, so the stimulus never leaves these bounds. A count word above DEPTH is the one out-of-range input that the bench sends on purpose, because the block defines its handling.

// File: rtl/spmv_pkg.sv
package spmv_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LD_CNT, S_LD_ROW, S_LD_COL, S_LD_VAL,
    S_X_WAIT, S_MULT, S_CLR, S_SUM, S_EMIT, S_DONE
  } st_e;
endpackage

// File: rtl/spmv_store.sv
module spmv_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/spmv_accum.sv
module spmv_accum #(
  parameter int N      = 8,
  parameter int PROD_W = 32,
  localparam int IW    = $clog2(N),
  localparam int ACC_W = PROD_W + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [IW-1:0]     add_row,
  input  logic [PROD_W-1:0] add_val,
  input  logic [IW-1:0]     rd_idx,
  output logic [ACC_W-1:0]  rd_data
);
  logic [ACC_W-1:0] acc_q [N];
  logic [ACC_W-1:0] add_ext;

  assign add_ext = {{IW{add_val[PROD_W-1]}}, add_val};

  for (genvar g = 0; g < N; g++) begin : g_acc
    logic [ACC_W-1:0] acc_d;
    logic             acc_en;

    always_comb begin
      acc_en = clr || (add_en && (add_row == IW'(g)));
      acc_d  = clr ? '0 : acc_q[g] + add_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q[g] <= '0;
      else if (acc_en) acc_q[g] <= acc_d;
    end

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q[g] == '0)); // R6
  end

  assign rd_data = acc_q[rd_idx];
endmodule

// File: rtl/spmv_engine.sv
module spmv_engine
  import spmv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N      = 8,
  parameter int DEPTH  = 16,
  localparam int IW    = $clog2(N),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = 2 * DATA_W,
  localparam int ACC_W = PW + IW,
  localparam int EW    = 2 * IW + DATA_W,
  localparam int BW    = IW + PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data,
  output logic              done,
  output logic              load_err
);
  localparam logic [DATA_W-1:0] DEPTH_W = DATA_W'(DEPTH);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  st_e               state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d, wptr_q, wptr_d, ptr_q, ptr_d;
  logic [IW-1:0]     row_q, row_d, col_q, col_d, colj_q, colj_d, oidx_q, oidx_d;
  logic [DATA_W-1:0] x_q, x_d;
  logic              err_q, err_d;

  logic              in_fire, out_fire, hit, in_buf;
  logic [EW-1:0]     ent;
  logic [BW-1:0]     bent;
  logic [IW-1:0]     ent_row, ent_col, b_row;
  logic [DATA_W-1:0] ent_val;
  logic [PW-1:0]     prod, b_val;

  assign ent_row = ent[EW-1 -: IW];
  assign ent_col = ent[EW-IW-1 -: IW];
  assign ent_val = ent[DATA_W-1:0];
  assign b_row   = bent[BW-1 -: IW];
  assign b_val   = bent[PW-1:0];
  assign prod    = PW'($signed(ent_val) * $signed(x_q));
  assign in_buf  = ptr_q < cnt_q;
  assign hit     = in_buf && (ent_col == colj_q);

  assign in_ready  = (state_q inside {S_LD_CNT, S_LD_ROW, S_LD_COL, S_LD_VAL, S_X_WAIT});
  assign out_valid = (state_q == S_EMIT);
  assign done      = (state_q == S_DONE);
  assign load_err  = err_q;
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  spmv_store #(.W(EW), .DEPTH(DEPTH)) u_coord (
    .clk(clk), .we((state_q == S_LD_VAL) && in_fire), .waddr(wptr_q[AW-1:0]),
    .wdata({row_q, col_q, in_data}), .raddr(ptr_q[AW-1:0]), .rdata(ent));

  spmv_store #(.W(BW), .DEPTH(DEPTH)) u_prod (
    .clk(clk), .we((state_q == S_MULT) && hit), .waddr(ptr_q[AW-1:0]),
    .wdata({ent_row, prod}), .raddr(ptr_q[AW-1:0]), .rdata(bent));

  spmv_accum #(.N(N), .PROD_W(PW)) u_acc (
    .clk(clk), .rst_n(rst_sn), .clr(state_q == S_CLR),
    .add_en((state_q == S_SUM) && in_buf), .add_row(b_row), .add_val(b_val),
    .rd_idx(oidx_q), .rd_data(out_data));

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; wptr_d = wptr_q; ptr_d = ptr_q;
    row_d = row_q; col_d = col_q; colj_d = colj_q; oidx_d = oidx_q;
    x_d = x_q; err_d = err_q;
    unique case (state_q)
      S_IDLE: begin
        colj_d  = '0;
        ptr_d   = '0;
        state_d = reload ? S_LD_CNT : S_X_WAIT;
      end
      S_LD_CNT: if (in_fire) begin
        wptr_d = '0;
        if (in_data > DEPTH_W) begin
          err_d = 1'b1; cnt_d = '0; state_d = S_IDLE;
        end else begin
          err_d   = 1'b0;
          cnt_d   = in_data[CW-1:0];
          state_d = (in_data == '0) ? S_X_WAIT : S_LD_ROW;
        end
      end
      S_LD_ROW: if (in_fire) begin row_d = in_data[IW-1:0]; state_d = S_LD_COL; end
      S_LD_COL: if (in_fire) begin col_d = in_data[IW-1:0]; state_d = S_LD_VAL; end
      S_LD_VAL: if (in_fire) begin
        wptr_d  = wptr_q + CW'(1);
        state_d = (wptr_q + CW'(1) == cnt_q) ? S_X_WAIT : S_LD_ROW;
      end
      S_X_WAIT: if (in_fire) begin x_d = in_data; state_d = S_MULT; end
      S_MULT: begin
        if (hit) ptr_d = ptr_q + CW'(1);
        else if (colj_q == IW'(N - 1)) state_d = S_CLR;
        else begin colj_d = colj_q + IW'(1); state_d = S_X_WAIT; end
      end
      S_CLR: begin ptr_d = '0; state_d = S_SUM; end
      S_SUM: begin
        if (in_buf) ptr_d = ptr_q + CW'(1);
        else begin oidx_d = '0; state_d = S_EMIT; end
      end
      S_EMIT: if (out_fire) begin
        if (oidx_q == IW'(N - 1)) state_d = S_DONE;
        else oidx_d = oidx_q + IW'(1);
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= S_IDLE; cnt_q <= '0; wptr_q <= '0; ptr_q <= '0;
      row_q <= '0; col_q <= '0; colj_q <= '0; oidx_q <= '0;
      x_q <= '0; err_q <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; wptr_q <= wptr_d; ptr_q <= ptr_d;
      row_q <= row_d; col_q <= col_d; colj_q <= colj_d; oidx_q <= oidx_d;
      x_q <= x_d; err_q <= err_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= CW'(DEPTH)); // R3
  AST_OVERSIZE_ERR: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == S_LD_CNT && in_fire && in_data > DEPTH_W) |=> (load_err && !in_ready)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_fire && oidx_q == IW'(N - 1)) |=> (done && !out_valid)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done); // R8
  AST_NO_IN_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid || done) |-> !in_ready); // R8
endmodule

// File: tb/spmv_engine_tb.sv
module spmv_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int N      = 8;
  localparam int DEPTH  = 16;
  localparam int ACC_W  = 2 * DATA_W + $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, reload = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, done, load_err;
  logic [ACC_W-1:0] out_data;

  int checks = 0, fails = 0, cyc = 0, t0 = 0, t1 = 0;
  bit finished = 1'b0;
  int m_row [DEPTH], m_col [DEPTH], m_val [DEPTH];
  int m_cnt = 0;
  int xv [N];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spmv_engine #(.DATA_W(DATA_W), .N(N), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reload(reload), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done), .load_err(load_err));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int w);
    in_valid = 1'b1;
    in_data  = DATA_W'(w);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load_matrix();
    reload = 1'b1;
    send(m_cnt);
    for (int k = 0; k < m_cnt; k++) begin
      send(m_row[k]); send(m_col[k]); send(m_val[k]);
    end
  endtask

  function automatic longint expect_y(input int i);
    longint s = 0;
    for (int k = 0; k < m_cnt; k++)
      if (m_row[k] == i) s += longint'(m_val[k]) * longint'(xv[m_col[k]]);
    return s;
  endfunction

  // send the vector, then collect and check every result
  task automatic run_vector(input string req, input int stall_at);
    for (int j = 0; j < N; j++) begin
      send(xv[j]);
      if (j == 0) t0 = cyc;
    end
    for (int i = 0; i < N; i++) begin
      out_ready = (i != stall_at);
      while (!out_valid) @(negedge clk);
      if (i == 0) begin
        t1 = cyc;
        check("R9 latency within bound", longint'(t1 - t0 <= 2 * N + 2 * m_cnt + 4), 1);
      end
      check("R8 in_ready low while emitting", longint'(in_ready), 0);
      if (i == stall_at) begin
        logic [ACC_W-1:0] held = out_data;
        repeat (3) @(negedge clk);
        check("R7 valid held under stall", longint'(out_valid), 1);
        check("R7 data stable under stall", longint'(out_data == held), 1);
        out_ready = 1'b1;
      end
      check(req, longint'($signed(out_data)), expect_y(i));
      @(negedge clk);
    end
    out_ready = 1'b0;
    check("R8 done after last result", longint'(done), 1);
    @(negedge clk);
    check("R8 done is one cycle", longint'(done), 0);
  endtask

  task automatic set_a1();
    int r [10] = '{0, 5, 1, 0, 2, 7, 4, 6, 3, 7};
    int c [10] = '{0, 0, 1, 3, 3, 3, 4, 6, 6, 7};
    int v [10] = '{3, -2, 7, 4, -5, 1, -9, 2, 10, -1};
    m_cnt = 10;
    for (int k = 0; k < 10; k++) begin m_row[k] = r[k]; m_col[k] = c[k]; m_val[k] = v[k]; end
  endtask

  task automatic t_reset();
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 done after reset", longint'(done), 0);
    check("R1 load_err after reset", longint'(load_err), 0);
  endtask

  task automatic t_resident_before_load();
    reload = 1'b0; m_cnt = 0;
    for (int j = 0; j < N; j++) xv[j] = j + 1;
    run_vector("R1 empty matrix gives zero", -1);
  endtask

  task automatic t_nonresident_load();
    set_a1();
    load_matrix();
    check("R3 legal load keeps load_err low", longint'(load_err), 0);
    xv = '{5, -3, 100, 2, 11, 77, -4, 9};
    run_vector("R2 R4 R6 loaded product with empty columns", -1);
  endtask

  task automatic t_resident_reuse();
    reload = 1'b0;
    xv = '{-7, 8, 1, -6, 0, 3, 12, -20};
    run_vector("R5 resident reuse", 2);
  endtask

  task automatic t_full_scale();
    m_cnt = DEPTH;
    for (int j = 0; j < N; j++) begin
      m_row[2*j] = 0; m_col[2*j] = j; m_val[2*j] = -32768;
      m_row[2*j+1] = 1; m_col[2*j+1] = j; m_val[2*j+1] = 32767;
    end
    load_matrix();
    for (int j = 0; j < N; j++) xv[j] = -32768;
    run_vector("R4 full-scale sums without overflow", -1);
  endtask

  task automatic t_oversize();
    reload = 1'b1;
    send(DEPTH + 1);
    check("R3 load_err on oversize count", longint'(load_err), 1);
    reload = 1'b0; m_cnt = 0;
    for (int j = 0; j < N; j++) xv[j] = 9 - j;
    run_vector("R3 oversize empties matrix", -1);
    check("R3 load_err stays until legal load", longint'(load_err), 1);
    set_a1();
    load_matrix();
    check("R3 legal count clears load_err", longint'(load_err), 0);
    xv = '{1, 1, 1, 1, 1, 1, 1, 1};
    run_vector("R3 load after error works", -1);
  endtask

  task automatic t_zero_count();
    m_cnt = 0;
    load_matrix();
    xv = '{4, 4, 4, 4, 4, 4, 4, 4};
    run_vector("R6 zero-count matrix", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_resident_before_load();
    t_nonresident_load();
    t_resident_reuse();
    t_full_scale();
    t_oversize();
    t_zero_count();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule